// File: doc/BRIEF.md
# Scalar-Vector Memory Synchronization Controller

This block carries out a memory-synchronize request issued by a scalar core to its attached vector unit. When a request is accepted, the block stalls scalar issue. It then waits until the scalar side and both vector memory directions report no outstanding operations. At that point it either completes, returning a fixed 32-bit value to the scalar destination register, or faults when the vector unit holds a pending asynchronous exception.

The two exits follow different rules. Completion produces a one-cycle writeback pulse that carries the result. A fault produces a one-cycle fault pulse with no writeback, and it may be raised while memory operations are still outstanding. The fault kind tells the trap logic whether a vector-unit-disabled fault or a memory-management fault is to be taken. The vector busy flag is an input only so that it is explicitly ignored. It does not show that vector writes are visible to the scalar side, so it is never a completion condition. Nothing leaves this scalar/vector pair.

Top module: `svsync_ctrl`

## Requirements
- R1: One cycle after a request is accepted while `issue_stall` is low, `issue_stall` is high. It stays high through the cycle in which the writeback or fault pulse is shown.
- R2: With no exception pending, `wb_valid` pulses in the cycle after the first clock edge in the wait state at which `scalar_pending`, `vrd_pending` and `vwr_pending` are all zero. While any of them is non-zero, no pulse occurs.
- R3: During the `wb_valid` pulse, `wb_data` equals `RESULT_VALUE` (default 0). Outside the pulse it is 0.
- R4: If `exc_arith` or `exc_mem` is high at a clock edge in the wait state, `fault_valid` pulses in the next cycle and `wb_valid` stays low. This holds even when the counters are all zero at that edge, so a fault wins over a drain that finishes at the same time.
- R5: During the fault pulse, `fault_kind` is 1 (memory-management fault) when `exc_mem` was high at the deciding edge. Otherwise it is 0 (vector-unit-disabled fault, caused by an arithmetic exception).
- R6: `vec_busy` has no effect on the outputs. A request completes with `vec_busy` high once the counters are zero, and it keeps waiting with `vec_busy` low while any counter is non-zero.
- R7: `wb_valid` and `fault_valid` each last exactly one cycle and are never high together.
- R8: `issue_stall` is low in the cycle after a writeback or fault pulse. A request held high during the pulse cycle is not accepted.
- R9: After synchronous reset, `issue_stall`, `wb_valid`, `fault_valid`, `fault_kind` and `wb_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Memory-synchronize request from scalar issue |
| scalar_pending | input | CNT_W | Scalar memory operations in flight |
| vrd_pending | input | CNT_W | Vector memory reads outstanding |
| vwr_pending | input | CNT_W | Vector memory writes outstanding |
| vec_busy | input | 1 | Vector busy status (ignored) |
| exc_arith | input | 1 | Pending vector arithmetic exception |
| exc_mem | input | 1 | Pending asynchronous vector memory-management exception |
| issue_stall | output | 1 | Holds scalar issue |
| wb_valid | output | 1 | Writeback to scalar destination register |
| wb_data | output | DATA_W | Writeback value |
| fault_valid | output | 1 | Request ends in a fault |
| fault_kind | output | 1 | 0 vector-unit-disabled, 1 memory-management |

## Verification
The bench builds the block with `CNT_W` = 2, so each counter takes only four values. With that width it sweeps every combination of the three counters, the busy flag and both exception flags, 512 cases in all. Every one of them gets its exit, fault kind, pulse timing and stall release computed arithmetically. Directed cases add an exception that arrives partway through a wait, and requests held during the exit cycle.

// File: rtl/svsync_pkg.sv
package svsync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_DRAIN = 2'd1,
    ST_COMPLETE   = 2'd2,
    ST_FAULT      = 2'd3
  } sync_state_t;

  typedef enum logic {
    FK_VEC_DISABLED = 1'b0,
    FK_MEM_MGMT     = 1'b1
  } fault_kind_t;
endpackage

// File: rtl/svsync_drain_detect.sv
module svsync_drain_detect #(
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 6
) (
  input  logic [NUM_SRC-1:0][CNT_W-1:0] counts,
  output logic                          drained
);
  logic [NUM_SRC-1:0] busy_src;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign busy_src[g] = |counts[g];
  end

  assign drained = ~|busy_src;
endmodule

// File: rtl/svsync_exc_sel.sv
module svsync_exc_sel
  import svsync_pkg::*;
(
  input  logic        exc_arith,
  input  logic        exc_mem,
  output logic        exc_pending,
  output fault_kind_t exc_kind
);
  always_comb begin
    exc_pending = exc_arith | exc_mem;
    exc_kind    = exc_mem ? FK_MEM_MGMT : FK_VEC_DISABLED;
  end
endmodule

// File: rtl/svsync_fsm.sv
module svsync_fsm
  import svsync_pkg::*;
#(
  parameter int              DATA_W       = 32,
  parameter logic [DATA_W-1:0] RESULT_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              drained,
  input  logic              exc_pending,
  input  fault_kind_t       exc_kind,
  output logic              stall,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data,
  output logic              fault_valid,
  output fault_kind_t       fault_kind
);
  sync_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      stall       <= 1'b0;
      wb_valid    <= 1'b0;
      wb_data     <= '0;
      fault_valid <= 1'b0;
      fault_kind  <= FK_VEC_DISABLED;
    end else begin
      wb_valid    <= 1'b0;
      wb_data     <= '0;
      fault_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            state <= ST_WAIT_DRAIN;
            stall <= 1'b1;
          end
        end
        ST_WAIT_DRAIN: begin
          if (exc_pending) begin
            state       <= ST_FAULT;
            fault_valid <= 1'b1;
            fault_kind  <= exc_kind;
          end else if (drained) begin
            state    <= ST_COMPLETE;
            wb_valid <= 1'b1;
            wb_data  <= RESULT_VALUE;
          end
        end
        ST_COMPLETE, ST_FAULT: begin
          state <= ST_IDLE;
          stall <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/svsync_ctrl.sv
module svsync_ctrl
  import svsync_pkg::*;
#(
  parameter int                CNT_W        = 6,
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] RESULT_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_req,
  input  logic [CNT_W-1:0]  scalar_pending,
  input  logic [CNT_W-1:0]  vrd_pending,
  input  logic [CNT_W-1:0]  vwr_pending,
  input  logic              vec_busy,
  input  logic              exc_arith,
  input  logic              exc_mem,
  output logic              issue_stall,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data,
  output logic              fault_valid,
  output logic              fault_kind
);
  localparam int NUM_SRC = 3;

  logic [NUM_SRC-1:0][CNT_W-1:0] counts;
  logic                          drained;
  logic                          exc_pending;
  fault_kind_t                   exc_kind;
  fault_kind_t                   fk_q;
  logic                          busy_unused;

  // Busy status is deliberately not a completion condition.
  assign busy_unused = vec_busy;
  assign counts      = {vwr_pending, vrd_pending, scalar_pending};

  svsync_drain_detect #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_drain (
    .counts  (counts),
    .drained (drained)
  );

  svsync_exc_sel u_exc (
    .exc_arith   (exc_arith),
    .exc_mem     (exc_mem),
    .exc_pending (exc_pending),
    .exc_kind    (exc_kind)
  );

  svsync_fsm #(.DATA_W(DATA_W), .RESULT_VALUE(RESULT_VALUE)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req         (sync_req),
    .drained     (drained),
    .exc_pending (exc_pending),
    .exc_kind    (exc_kind),
    .stall       (issue_stall),
    .wb_valid    (wb_valid),
    .wb_data     (wb_data),
    .fault_valid (fault_valid),
    .fault_kind  (fk_q)
  );

  assign fault_kind = fk_q;
endmodule

// File: rtl/svsync_ctrl_chk.sv
module svsync_ctrl_chk #(
  parameter int                CNT_W        = 6,
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] RESULT_VALUE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_req,
  input logic [CNT_W-1:0]  scalar_pending,
  input logic [CNT_W-1:0]  vrd_pending,
  input logic [CNT_W-1:0]  vwr_pending,
  input logic              exc_arith,
  input logic              exc_mem,
  input logic              issue_stall,
  input logic              wb_valid,
  input logic [DATA_W-1:0] wb_data,
  input logic              fault_valid,
  input logic              fault_kind
);
  p_stall_on_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (sync_req && !issue_stall) |=> issue_stall);

  p_pulse_under_stall_r1: assert property (@(posedge clk) disable iff (rst)
    (wb_valid || fault_valid) |-> issue_stall);

  p_complete_needs_drain_r2: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(scalar_pending == '0 && vrd_pending == '0 && vwr_pending == '0));

  p_wb_value_r3: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_data == RESULT_VALUE));

  p_fault_needs_exc_r4: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> $past(exc_arith || exc_mem));

  p_fault_kind_r5: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_kind == $past(exc_mem)));

  p_pulses_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && fault_valid));

  p_wb_single_r7: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid);

  p_fault_single_r7: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);

  p_stall_release_r8: assert property (@(posedge clk) disable iff (rst)
    (wb_valid || fault_valid) |=> !issue_stall);
endmodule

bind svsync_ctrl svsync_ctrl_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .RESULT_VALUE(RESULT_VALUE)
) u_chk (
  .clk(clk), .rst(rst), .sync_req(sync_req),
  .scalar_pending(scalar_pending), .vrd_pending(vrd_pending),
  .vwr_pending(vwr_pending), .exc_arith(exc_arith), .exc_mem(exc_mem),
  .issue_stall(issue_stall), .wb_valid(wb_valid), .wb_data(wb_data),
  .fault_valid(fault_valid), .fault_kind(fault_kind)
);

// File: tb/sim_svsync_ctrl.sv
`timescale 1ns/1ps
module sim_svsync_ctrl;
  localparam int CNT_W  = 2;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sync_req = 1'b0;
  logic [CNT_W-1:0]  scalar_pending = '0;
  logic [CNT_W-1:0]  vrd_pending = '0;
  logic [CNT_W-1:0]  vwr_pending = '0;
  logic              vec_busy = 1'b0;
  logic              exc_arith = 1'b0;
  logic              exc_mem = 1'b0;
  logic              issue_stall;
  logic              wb_valid;
  logic [DATA_W-1:0] wb_data;
  logic              fault_valid;
  logic              fault_kind;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  svsync_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .RESULT_VALUE('0)) u0 (
    .clk(clk), .rst(rst), .sync_req(sync_req),
    .scalar_pending(scalar_pending), .vrd_pending(vrd_pending),
    .vwr_pending(vwr_pending), .vec_busy(vec_busy),
    .exc_arith(exc_arith), .exc_mem(exc_mem),
    .issue_stall(issue_stall), .wb_valid(wb_valid), .wb_data(wb_data),
    .fault_valid(fault_valid), .fault_kind(fault_kind)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Outputs while idle after an exit: stall released, no pulses.
  task automatic chk_released(input string tag);
    chk({tag, " R8 stall released"}, 32'(issue_stall), 32'd0);
    chk({tag, " R7 wb pulse ended"}, 32'(wb_valid), 32'd0);
    chk({tag, " R7 fault pulse ended"}, 32'(fault_valid), 32'd0);
  endtask

  task automatic chk_waiting(input string tag);
    chk({tag, " R1 stall held"}, 32'(issue_stall), 32'd1);
    chk({tag, " R2 no early wb"}, 32'(wb_valid), 32'd0);
    chk({tag, " R4 no early fault"}, 32'(fault_valid), 32'd0);
  endtask

  task automatic issue_req();
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk) sync_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 stall", 32'(issue_stall), 32'd0);
    chk("R9 wb_valid", 32'(wb_valid), 32'd0);
    chk("R9 fault_valid", 32'(fault_valid), 32'd0);
    chk("R9 fault_kind", 32'(fault_kind), 32'd0);
    chk("R9 wb_data", wb_data, 32'd0);

    // Full sweep of counters, busy and exception flags held static.
    for (int code = 0; code < 512; code++) begin
      logic [8:0] cv;
      bit drained_c;
      bit exc_c;
      cv = code[8:0];
      @(negedge clk);
      scalar_pending = cv[1:0];
      vrd_pending    = cv[3:2];
      vwr_pending    = cv[5:4];
      vec_busy       = cv[6];
      exc_arith      = cv[7];
      exc_mem        = cv[8];
      drained_c = (cv[5:0] == 6'd0);
      exc_c     = cv[7] | cv[8];
      issue_req();
      chk_waiting("sweep accept");
      @(negedge clk);
      if (exc_c) begin
        // R4 fault wins, even when drained at the same edge; R5 kind
        chk("R4 fault pulse", 32'(fault_valid), 32'd1);
        chk("R4 no writeback on fault", 32'(wb_valid), 32'd0);
        chk("R5 fault kind", 32'(fault_kind), 32'(cv[8]));
        chk("R1 stall during fault", 32'(issue_stall), 32'd1);
      end else if (drained_c) begin
        // R2 completes; R6 busy ignored when high
        chk("R2 R6 writeback pulse", 32'(wb_valid), 32'd1);
        chk("R3 result value", wb_data, 32'd0);
        chk("R7 no fault with wb", 32'(fault_valid), 32'd0);
        chk("R1 stall during wb", 32'(issue_stall), 32'd1);
      end else begin
        // R2 R6 keeps waiting while any counter non-zero, whatever busy is
        chk_waiting("sweep R6 undrained");
        repeat (2) begin
          @(negedge clk);
          chk_waiting("sweep R2 hold");
        end
        scalar_pending = '0;
        vrd_pending    = '0;
        vwr_pending    = '0;
        @(negedge clk);
        chk("R2 late drain wb", 32'(wb_valid), 32'd1);
        chk("R3 late drain value", wb_data, 32'd0);
      end
      @(negedge clk);
      chk_released("sweep exit");
    end

    // Exception arriving partway through a wait.
    @(negedge clk);
    exc_arith = 1'b0; exc_mem = 1'b0; vec_busy = 1'b0;
    scalar_pending = 2'd1; vrd_pending = 2'd3; vwr_pending = 2'd0;
    issue_req();
    repeat (2) begin
      @(negedge clk);
      chk_waiting("late exc hold");
    end
    exc_arith = 1'b1;
    @(negedge clk);
    chk("R4 late arith fault", 32'(fault_valid), 32'd1);
    chk("R5 arith gives disabled kind", 32'(fault_kind), 32'd0);
    exc_arith = 1'b0;
    @(negedge clk);
    chk_released("late exc exit");

    // Request held through the completion cycle is not accepted.
    scalar_pending = '0; vrd_pending = '0; vwr_pending = '0;
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 wb with req held", 32'(wb_valid), 32'd1);
    @(negedge clk);
    chk("R8 held req ignored at exit", 32'(issue_stall), 32'd0);
    sync_req = 1'b0;
    @(negedge clk);
    chk("R8 no re-accept", 32'(issue_stall), 32'd0);
    @(negedge clk);
    chk("R8 still idle", 32'(issue_stall), 32'd0);

    // Request held through the fault cycle is not accepted.
    exc_mem = 1'b1;
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 mem fault kind", 32'(fault_kind), 32'd1);
    chk("R4 mem fault pulse", 32'(fault_valid), 32'd1);
    @(negedge clk);
    chk("R8 held req ignored after fault", 32'(issue_stall), 32'd0);
    sync_req = 1'b0;
    exc_mem = 1'b0;
    @(negedge clk);
    chk("R8 idle after fault", 32'(issue_stall), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule